// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block moves a processor from normal execution into an interrupt handler. An external arbiter presents one winning request as a number/level pair. The sequencer accepts it only at an instruction boundary. The exception is a long-running string or repeat instruction, which it suspends on the spot. Once accepted, the request goes through a fixed series of steps, and each step leaves a visible trace at the ports:

1. Acknowledge the source.
2. Take a private copy of the flag word.
3. Clear the interrupt-enable, single-step and stack-select flags.
4. Save the copied flags and then the program counter.
5. Raise the priority level field.
6. Load the handler address into the program counter.

A normal interrupt saves its state on the interrupt stack through a memory write port, then fetches its handler address from a vector table through a memory read port. The single high-speed interrupt does neither. It saves into two dedicated save registers and takes its handler address from a dedicated vector register, so its entry has a fixed length of eight cycles.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy`, `done`, `req_clr`, `suspend`, `flg_we`, `pc_we`, `isp_we`, `mw_valid` and `mr_valid` are all 0.
- R2: A request is accepted only when the sequencer is idle, `req_valid` is 1, and `insn_done` or `insn_intr` is 1. In the cycle after acceptance, `busy` is 1 and `req_clr` pulses for one cycle carrying the accepted number. While `busy` is 1, no further request is acknowledged.
- R3: `suspend` pulses together with `req_clr` exactly when acceptance came from `insn_intr` without `insn_done`. With neither input set, a pending request is never accepted.
- R4: The flag value saved (stack word or `fsave_flg`) equals `flg_in` as it was before the sequencer's first flag write.
- R5: The first `flg_we` write equals the saved flags with bit 6 (interrupt enable), bit 3 (single step) and bit 7 (stack select) cleared, and all other bits kept.
- R6: A normal interrupt pushes two 32-bit words. The flag word (zero-extended) goes to `isp_in-4`, then the PC goes to `isp_in-8`, with wrap-around modulo 2^32. `isp_we` then writes `isp_in-8` once.
- R7: A high-speed interrupt (`req_fast`=1) performs no memory access. It leaves the flags in `fsave_flg` and the PC in `fsave_pc`, and `done` arrives exactly 8 cycles after the acceptance edge.
- R8: The second `flg_we` write equals the R5 value with bits [14:12] replaced by the accepted request level.
- R9: A normal interrupt reads one word from `vec_base + 4*number` and loads it into the PC. A high-speed interrupt loads `fast_vec` instead.
- R10: `done` is a one-cycle pulse that coincides with `pc_we`, and `busy` falls in the cycle after it.
- R11: While `mw_valid` or `mr_valid` is held without its ready signal, the address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Arbitrated request pending |
| req_num | input | NW | Winning interrupt number |
| req_lvl | input | LW | Winning request level |
| req_fast | input | 1 | Winner is the high-speed interrupt |
| insn_done | input | 1 | Current instruction completes this cycle |
| insn_intr | input | 1 | Current instruction may be suspended |
| req_clr | output | 1 | Pulse: clear the acknowledged source's request bit |
| req_clr_num | output | NW | Number whose request bit is cleared |
| suspend | output | 1 | Pulse: abandon the running instruction |
| flg_in | input | FW | Current flag register |
| flg_we | output | 1 | Flag register write strobe |
| flg_wdata | output | FW | Flag register write value |
| pc_in | input | AW | Current program counter to save |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | AW | Handler address |
| isp_in | input | AW | Interrupt stack pointer |
| isp_we | output | 1 | Stack pointer write strobe |
| isp_wdata | output | AW | Updated stack pointer |
| fsave_flg | output | FW | High-speed flag save register |
| fsave_pc | output | AW | High-speed PC save register |
| vec_base | input | AW | Vector table base address |
| fast_vec | input | AW | High-speed handler address |
| mw_valid | output | 1 | Stack write request |
| mw_ready | input | 1 | Stack write accepted |
| mw_addr | output | AW | Stack write address |
| mw_data | output | AW | Stack write data |
| mr_valid | output | 1 | Vector read request |
| mr_ready | input | 1 | Vector read completes, data valid |
| mr_addr | output | AW | Vector read address |
| mr_rdata | input | AW | Vector read data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Pulse: handler address loaded |

## Verification
A bad sequencer state shows up at the ports within the same entry sequence. A state that skips or repeats a step changes how many flag writes, stack pushes or vector reads are seen, or changes their order. A snapshot taken late causes the pushed flag word to carry the already-cleared bits. A stack pointer that steps wrongly moves the second push and the final `isp_wdata` away from `isp_in-8`. On the high-speed path, any extra or missing state moves `done` off its fixed eighth cycle, which is visible within ten cycles of acceptance.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ACK, ST_SNAP, ST_CLRF, ST_PUSHF,
    ST_PUSHP, ST_LVL, ST_VEC, ST_LOAD
  } seq_state_e;
endpackage

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int FW      = 16,
  parameter int LW      = 3,
  parameter int IE_BIT  = 6,
  parameter int SS_BIT  = 3,
  parameter int SP_BIT  = 7,
  parameter int LVL_LSB = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snap_en,
  input  logic [FW-1:0] flg_in,
  input  logic [LW-1:0] lvl,
  output logic [FW-1:0] snap_q,
  output logic [FW-1:0] masked,
  output logic [FW-1:0] leveled
);
  localparam logic [FW-1:0] CLR_MASK = FW'((1 << IE_BIT) | (1 << SS_BIT) | (1 << SP_BIT));
  localparam logic [FW-1:0] LVL_MASK = FW'(((1 << LW) - 1) << LVL_LSB);

  // Private copy, taken before any flag is rewritten
  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (snap_en) snap_q <= flg_in;
  end

  always_comb begin
    masked  = snap_q & ~CLR_MASK;
    leveled = (masked & ~LVL_MASK) | (FW'(lvl) << LVL_LSB);
  end

  a_r4_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !snap_en |=> $stable(snap_q));
endmodule

// File: rtl/irq_save_path.sv
module irq_save_path #(
  parameter int AW = 32,
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          isp_load,
  input  logic [AW-1:0] isp_in,
  input  logic          push_f,
  input  logic          push_p,
  input  logic          fast,
  input  logic [FW-1:0] flg_word,
  input  logic [AW-1:0] pc_word,
  input  logic          mw_ready,
  output logic          mw_valid,
  output logic [AW-1:0] mw_addr,
  output logic [AW-1:0] mw_data,
  output logic [AW-1:0] sp_q,
  output logic [FW-1:0] fsave_flg,
  output logic [AW-1:0] fsave_pc
);
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);

  logic xfer;

  always_comb begin
    mw_valid = !fast && (push_f || push_p);
    mw_addr  = sp_q - WORD_BYTES;
    mw_data  = push_f ? {{(AW-FW){1'b0}}, flg_word} : pc_word;
    xfer     = mw_valid && mw_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q      <= '0;
      fsave_flg <= '0;
      fsave_pc  <= '0;
    end else begin
      if (isp_load)  sp_q <= isp_in;
      else if (xfer) sp_q <= sp_q - WORD_BYTES;
      if (fast && push_f) fsave_flg <= flg_word;
      if (fast && push_p) fsave_pc  <= pc_word;
    end
  end

  a_r11_mw_hold: assert property (@(posedge clk) disable iff (rst)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));
  a_r6_sp_step: assert property (@(posedge clk) disable iff (rst)
    xfer |=> sp_q == $past(sp_q) - WORD_BYTES);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW      = 32,
  parameter int FW      = 16,
  parameter int NW      = 6,
  parameter int LW      = 3,
  parameter int IE_BIT  = 6,
  parameter int SS_BIT  = 3,
  parameter int SP_BIT  = 7,
  parameter int LVL_LSB = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [NW-1:0] req_num,
  input  logic [LW-1:0] req_lvl,
  input  logic          req_fast,
  input  logic          insn_done,
  input  logic          insn_intr,
  output logic          req_clr,
  output logic [NW-1:0] req_clr_num,
  output logic          suspend,
  input  logic [FW-1:0] flg_in,
  output logic          flg_we,
  output logic [FW-1:0] flg_wdata,
  input  logic [AW-1:0] pc_in,
  output logic          pc_we,
  output logic [AW-1:0] pc_wdata,
  input  logic [AW-1:0] isp_in,
  output logic          isp_we,
  output logic [AW-1:0] isp_wdata,
  output logic [FW-1:0] fsave_flg,
  output logic [AW-1:0] fsave_pc,
  input  logic [AW-1:0] vec_base,
  input  logic [AW-1:0] fast_vec,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [AW-1:0] mw_data,
  output logic          mr_valid,
  input  logic          mr_ready,
  output logic [AW-1:0] mr_addr,
  input  logic [AW-1:0] mr_rdata,
  output logic          busy,
  output logic          done
);
  localparam logic [FW-1:0] CLR_MASK = FW'((1 << IE_BIT) | (1 << SS_BIT) | (1 << SP_BIT));
  localparam int VEC_SHIFT = 2;

  seq_state_e    st;
  logic [NW-1:0] num_q;
  logic [LW-1:0] lvl_q;
  logic          fast_q, susp_q;
  logic [AW-1:0] pc_q, vec_q, sp_q;
  logic [FW-1:0] snap_q, masked, leveled;
  logic          accept, push_done;

  assign accept = (st == ST_IDLE) && req_valid && (insn_done || insn_intr);
  assign push_done = fast_q || (mw_valid && mw_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      num_q  <= '0;
      lvl_q  <= '0;
      fast_q <= 1'b0;
      susp_q <= 1'b0;
      pc_q   <= '0;
      vec_q  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          st     <= ST_ACK;
          num_q  <= req_num;
          lvl_q  <= req_lvl;
          fast_q <= req_fast;
          susp_q <= insn_intr && !insn_done;
        end
        ST_ACK:  st <= ST_SNAP;
        ST_SNAP: begin
          st   <= ST_CLRF;
          pc_q <= pc_in;
        end
        ST_CLRF:  st <= ST_PUSHF;
        ST_PUSHF: if (push_done) st <= ST_PUSHP;
        ST_PUSHP: if (push_done) st <= ST_LVL;
        ST_LVL:   st <= ST_VEC;
        ST_VEC: if (fast_q || mr_ready) begin
          st    <= ST_LOAD;
          vec_q <= fast_q ? fast_vec : mr_rdata;
        end
        ST_LOAD:  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  irq_flag_unit #(
    .FW(FW), .LW(LW), .IE_BIT(IE_BIT), .SS_BIT(SS_BIT),
    .SP_BIT(SP_BIT), .LVL_LSB(LVL_LSB)
  ) u_flags (
    .clk(clk), .rst(rst), .snap_en(st == ST_SNAP), .flg_in(flg_in),
    .lvl(lvl_q), .snap_q(snap_q), .masked(masked), .leveled(leveled)
  );

  irq_save_path #(.AW(AW), .FW(FW)) u_save (
    .clk(clk), .rst(rst), .isp_load(st == ST_SNAP), .isp_in(isp_in),
    .push_f(st == ST_PUSHF), .push_p(st == ST_PUSHP), .fast(fast_q),
    .flg_word(snap_q), .pc_word(pc_q), .mw_ready(mw_ready),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
    .sp_q(sp_q), .fsave_flg(fsave_flg), .fsave_pc(fsave_pc)
  );

  always_comb begin
    busy        = (st != ST_IDLE);
    req_clr     = (st == ST_ACK);
    req_clr_num = num_q;
    suspend     = (st == ST_ACK) && susp_q;
    flg_we      = (st == ST_CLRF) || (st == ST_LVL);
    flg_wdata   = (st == ST_LVL) ? leveled : masked;
    isp_we      = (st == ST_LVL) && !fast_q;
    isp_wdata   = sp_q;
    mr_valid    = (st == ST_VEC) && !fast_q;
    mr_addr     = vec_base + (AW'(num_q) << VEC_SHIFT);
    pc_we       = (st == ST_LOAD);
    pc_wdata    = vec_q;
    done        = (st == ST_LOAD);
  end

  a_r2_clr_after_idle: assert property (@(posedge clk) disable iff (rst)
    req_clr |-> !$past(busy));
  a_r2_clr_one_shot: assert property (@(posedge clk) disable iff (rst)
    req_clr |=> !req_clr);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  a_r5_flags_cleared: assert property (@(posedge clk) disable iff (rst)
    flg_we |-> (flg_wdata & CLR_MASK) == '0);
  a_r11_mr_hold: assert property (@(posedge clk) disable iff (rst)
    mr_valid && !mr_ready |=> mr_valid && $stable(mr_addr));
  a_r7_fast_no_read: assert property (@(posedge clk) disable iff (rst)
    fsave_flg != $past(fsave_flg) |-> !mw_valid && !mr_valid);
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0, req_fast = 0, insn_done = 0, insn_intr = 0;
  logic [5:0]  req_num = 0;
  logic [2:0]  req_lvl = 0;
  logic [15:0] flg_in = 0;
  logic [31:0] pc_in = 0, isp_in = 0, vec_base = 32'h0000_F000, fast_vec = 32'h00AB_CD00;
  logic        mw_ready = 0, mr_ready = 0;
  logic [31:0] mr_rdata = 0;
  logic        req_clr, suspend, flg_we, pc_we, isp_we, mw_valid, mr_valid, busy, done;
  logic [5:0]  req_clr_num;
  logic [15:0] flg_wdata, fsave_flg;
  logic [31:0] pc_wdata, isp_wdata, fsave_pc, mw_addr, mw_data, mr_addr;

  int n_chk = 0, n_bad = 0;
  bit wd_hit = 0;

  always #5 clk = ~clk;

  irq_entry_seq u0 (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_clr(logic [15:0] f);
    return f & ~16'h00C8;
  endfunction
  function automatic logic [15:0] exp_lvl(logic [15:0] f, logic [2:0] l);
    return (exp_clr(f) & ~16'h7000) | (16'(l) << 12);
  endfunction
  function automatic logic [31:0] vec_mem(logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic do_irq(logic [5:0] num, logic [2:0] lvl, bit fast, bit susp,
                        logic [15:0] flg, logic [31:0] pc, logic [31:0] isp, bit stall);
    logic [15:0] fw[2];
    logic [31:0] pa[2], pd[2], ra, isp_w;
    int nf = 0, np = 0, nr = 0, ni = 0, extra_clr = 0, cyc = 1;
    bit got_done = 0;
    @(negedge clk);
    req_valid = 1; req_num = num; req_lvl = lvl; req_fast = fast;
    insn_done = !susp; insn_intr = susp; flg_in = flg; pc_in = pc; isp_in = isp;
    @(negedge clk);
    chk(busy && req_clr, "R2 ack", {busy, req_clr}, 2'b11);
    chk(req_clr_num == num, "R2 number", req_clr_num, num);
    chk(suspend == susp, "R3 suspend", suspend, susp);
    // keep a competing request at a boundary during busy
    req_num = num ^ 6'h15; insn_done = 1; insn_intr = 0;
    while (!got_done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (req_clr) extra_clr++;
      if (flg_we) begin
        if (nf < 2) fw[nf] = flg_wdata;
        nf++;
        flg_in = flg_wdata;
      end
      if (isp_we) begin ni++; isp_w = isp_wdata; end
      mw_ready = 0; mr_ready = 0;
      if (mw_valid && (!stall || $urandom_range(2) != 0)) begin
        mw_ready = 1;
        if (np < 2) begin pa[np] = mw_addr; pd[np] = mw_data; end
        np++;
      end
      if (mr_valid && (!stall || $urandom_range(2) != 0)) begin
        mr_ready = 1; ra = mr_addr; mr_rdata = vec_mem(mr_addr); nr++;
      end
      if (done) begin
        got_done = 1;
        chk(pc_we, "R10 done with pc_we", pc_we, 1);
        req_valid = 0; insn_done = 0;
        if (fast) chk(pc_wdata == fast_vec, "R9 fast vector", pc_wdata, fast_vec);
        else chk(pc_wdata == vec_mem(vbase_addr(num)), "R9 vector load", pc_wdata, vec_mem(vbase_addr(num)));
      end
    end
    if (!got_done) begin wd_hit = 1; chk(0, "R10 watchdog", cyc, 0); return; end
    chk(extra_clr == 0, "R2 no ack while busy", extra_clr, 0);
    chk(nf == 2, "R5 flag write count", nf, 2);
    if (nf == 2) begin
      chk(fw[0] == exp_clr(flg), "R5 cleared flags", fw[0], exp_clr(flg));
      chk(fw[1] == exp_lvl(flg, lvl), "R8 level field", fw[1], exp_lvl(flg, lvl));
    end
    if (fast) begin
      chk(np == 0 && nr == 0 && ni == 0, "R7 no memory", {np[7:0], nr[7:0], ni[7:0]}, 0);
      chk(fsave_flg == flg, "R4 fast flag save", fsave_flg, flg);
      chk(fsave_pc == pc, "R7 fast pc save", fsave_pc, pc);
      chk(cyc == 8, "R7 fixed length", cyc, 8);
    end else begin
      chk(np == 2 && nr == 1 && ni == 1, "R6 transfer count", {np[7:0], nr[7:0], ni[7:0]}, 24'h020101);
      if (np == 2) begin
        chk(pa[0] == isp - 4 && pd[0] == {16'h0, flg}, "R4 flag push", {pa[0], pd[0]}, {isp - 32'd4, 16'h0, flg});
        chk(pa[1] == isp - 8 && pd[1] == pc, "R6 pc push", {pa[1], pd[1]}, {isp - 32'd8, pc});
      end
      if (ni == 1) chk(isp_w == isp - 8, "R6 new stack pointer", isp_w, isp - 8);
      if (nr == 1) chk(ra == vbase_addr(num), "R9 vector address", ra, vbase_addr(num));
    end
    @(negedge clk);
    chk(!busy && !done, "R10 busy falls", {busy, done}, 0);
  endtask

  function automatic logic [31:0] vbase_addr(logic [5:0] n);
    return vec_base + {24'h0, n, 2'b00};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !req_clr && !suspend && !flg_we && !pc_we && !isp_we && !mw_valid && !mr_valid,
        "R1 reset state", {busy, done, mw_valid, mr_valid}, 0);
    rst = 0;
    // R3: pending request mid-instruction, neither boundary nor interruptible
    @(negedge clk); req_valid = 1; req_num = 6'd9;
    repeat (5) begin
      @(negedge clk);
      chk(!busy && !req_clr, "R3 no accept mid-instruction", {busy, req_clr}, 0);
    end
    req_valid = 0;
    // directed corner cases
    do_irq(6'd1, 3'd5, 0, 0, 16'hFFFF, 32'h0000_1234, 32'h0000_8000, 0);
    do_irq(6'd63, 3'd7, 0, 1, 16'h00C8, 32'hDEAD_BEE0, 32'h0000_0004, 1);
    do_irq(6'd0, 3'd0, 1, 0, 16'h7FFF, 32'h1111_2222, 32'h0000_0100, 0);
    do_irq(6'd7, 3'd2, 1, 1, 16'h0000, 32'h3333_4444, 32'h0000_0200, 0);
    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 40; i++)
      do_irq(6'($urandom), 3'($urandom), ($urandom_range(3) == 0), $urandom_range(1) == 1,
             16'($urandom), $urandom & ~32'h3, 32'h0001_0000 + ($urandom_range(1023) << 2), 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule